// File: doc/BRIEF.md
# Programmable Sinc Decimation Filter

This block turns the 1-bit output of a sigma-delta modulator into multi-bit samples at a lower rate. A divider on the master clock produces a filter-rate enable. The block sends that enable out, so the modulator can produce one bit per enable, and the filter takes in that bit on the same enable. Each input bit counts as +1 or −1. The value then passes through a cascade of boxcar (moving-sum) sections. The cascade holds 3 to 6 sections, chosen at run time, and every section has a programmable length. The result is then decimated by a separate programmable ratio.

Configuration comes in on two plain parallel words: an 8-bit rate word and a 16-bit shape word. Any change to a live configuration field restarts the filter from a clean state. Output samples are full precision and two's complement. Each sample comes with a one-cycle `out_valid` strobe. The output has no ready input, so the downstream logic cannot apply back-pressure: it must capture `out_data` in the cycle the strobe is high, or before the next strobe. `out_data` holds its value between strobes.

Top module: `sinc_decim`

## Requirements
- R1: `mod_clk_en` is high for one master-clock cycle in every D cycles. D is `cfg_rate[6:0]`, the code 0 gives D = 128, and the code 1 is treated as D = 2.
- R2: `cfg_shape[13:12]` selects the number of cascaded sections N: 00 gives 3, 01 gives 4, 10 gives 5 and 11 gives 6.
- R3: `cfg_shape[11:6]` sets the section length L from 1 to 64, and the code 0 gives 64. The length is independent of the decimation ratio.
- R4: `cfg_shape[5:0]` sets the decimation ratio M from 1 to 64, and the code 0 gives 64. Counting fresh input samples from 1, an output is produced at every sample number that is a multiple of M.
- R5: An input bit of 1 counts as +1 and a bit of 0 counts as −1. Each output equals the input stream passed N times through a length-L moving sum, starting from a zero history. The value is a 38-bit two's-complement number and is exact at the extremes, which are +2^36 and −2^36 when N = 6 and L = 64.
- R6: After reset, both configuration words read as zero in effect (D = 128, N = 3, L = 64, M = 64), `out_valid` is 0 and `out_data` is 0.
- R7: `cfg_rate[7]` and `cfg_shape[15:14]` are reserved. Changing them has no effect on the output and does not restart the filter.
- R8: A change to any live configuration field clears all filter state and counters. When the change is seen in the same cycle as a due output, the change takes priority: no strobe is given in the following cycle. After a change, no output is given until N×L fresh samples have been taken in.
- R9: `out_valid` lasts exactly one master-clock cycle. It rises in the cycle after the enable cycle in which the producing sample was consumed.
- R10: `out_data` changes only together with an `out_valid` strobe, and it holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_rate | input | 8 | Rate word: bits 6:0 set the divide code, bit 7 is reserved |
| cfg_shape | input | 16 | Shape word: bits 13:12 set the order, 11:6 the length and 5:0 the decimation; bits 15:14 are reserved |
| in_bit | input | 1 | Modulator bit, taken in on cycles where `mod_clk_en` is high |
| mod_clk_en | output | 1 | Filter-rate enable, one cycle wide |
| out_data | output | 38 | Filtered sample, two's complement |
| out_valid | output | 1 | One-cycle strobe marking a new `out_data` |

## Verification
A configuration change and a due decimated output can land on the same clock edge. In that case the restart must win, and no stale sample may escape. The bench provokes this by watching its own sample count. It changes the shape word exactly on the enable cycle that would have produced an output, then checks that `out_valid` stays low in the following cycle. It then runs a fresh stream and compares every output with a model that restarted from zero history. Any sample left over from before the restart would show up as a wrong value or an early strobe.

// File: rtl/sinc_pkg.sv
`timescale 1ns/1ps
package sinc_pkg;
  // Field widths of the control words (layout decoded by this block)
  localparam int RATE_W     = 7;
  localparam int ORDER_W    = 2;
  localparam int SECT_W     = 6;
  localparam int ORDER_BASE = 3;
  localparam int ORDER_MAX  = ORDER_BASE + (1 << ORDER_W) - 1;
  localparam int HIST_D     = 1 << SECT_W;
  // Sign bit, plus one bit so that +2^(SECT_W*ORDER_MAX) fits
  localparam int ACC_W      = 2 + SECT_W * ORDER_MAX;

  typedef struct packed {
    logic [RATE_W-1:0]  rate;
    logic [ORDER_W-1:0] order;
    logic [SECT_W-1:0]  len;
    logic [SECT_W-1:0]  dsr;
  } cfg_t;
endpackage

// File: rtl/sinc_rate_div.sv
`timescale 1ns/1ps
module sinc_rate_div #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr,
  input  logic [W-1:0] code,
  output logic         tick
);
  logic [W-1:0] cnt;
  logic [W-1:0] last;

  // code 0 -> 2^W, code 1 -> 2, otherwise code
  always_comb begin
    if (code == '0)              last = '1;
    else if (code == W'(1))      last = W'(1);
    else                         last = code - W'(1);
  end

  assign tick = (cnt == last);

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt <= '0;
    else if (clr || tick) cnt <= '0;
    else                 cnt <= cnt + W'(1);
  end
endmodule

// File: rtl/sinc_integrators.sv
`timescale 1ns/1ps
module sinc_integrators #(
  parameter int DW    = 38,
  parameter int NST   = 6,
  parameter int SEL_W = 2,
  parameter int BASE  = 3
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic [SEL_W-1:0]     sel,
  output logic signed [DW-1:0] y
);
  logic signed [DW-1:0] acc [NST];
  logic signed [DW-1:0] nxt [NST];

  // Modular running sums; wrap-around cancels in the combs
  always_comb begin
    nxt[0] = acc[0] + x;
    for (int k = 1; k < NST; k++) nxt[k] = acc[k] + nxt[k-1];
  end

  assign y = nxt[int'(sel) + BASE - 1];

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      for (int k = 0; k < NST; k++) acc[k] <= '0;
    end else if (en) begin
      for (int k = 0; k < NST; k++) acc[k] <= nxt[k];
    end
  end
endmodule

// File: rtl/sinc_combs.sv
`timescale 1ns/1ps
module sinc_combs #(
  parameter int DW    = 38,
  parameter int NST   = 6,
  parameter int SEL_W = 2,
  parameter int BASE  = 3,
  parameter int LW    = 6
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 en,
  input  logic signed [DW-1:0] x,
  input  logic [SEL_W-1:0]     sel,
  input  logic [LW-1:0]        len,
  output logic signed [DW-1:0] y
);
  localparam int DEPTH = 1 << LW;

  logic signed [DW-1:0] dl    [NST][DEPTH];
  logic signed [DW-1:0] stg_in[NST];
  logic signed [DW-1:0] stg_o [NST];
  logic [LW-1:0]        tap;

  // code 0 wraps to DEPTH-1, i.e. a delay of DEPTH samples
  assign tap = len - LW'(1);

  genvar k;
  generate
    for (k = 0; k < NST; k++) begin : g_stage
      if (k == 0) begin : g_first
        assign stg_in[k] = x;
      end else begin : g_next
        assign stg_in[k] = stg_o[k-1];
      end
      // Sections past the selected order pass data through
      assign stg_o[k] = (k < int'(sel) + BASE) ? stg_in[k] - dl[k][tap]
                                               : stg_in[k];
      always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
          for (int j = 0; j < DEPTH; j++) dl[k][j] <= '0;
        end else if (en) begin
          dl[k][0] <= stg_in[k];
          for (int j = 1; j < DEPTH; j++) dl[k][j] <= dl[k][j-1];
        end
      end
    end
  endgenerate

  assign y = stg_o[NST-1];
endmodule

// File: rtl/sinc_decim.sv
`timescale 1ns/1ps
module sinc_decim
  import sinc_pkg::*;
(
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [7:0]              cfg_rate,
  input  logic [15:0]             cfg_shape,
  input  logic                    in_bit,
  output logic                    mod_clk_en,
  output logic signed [ACC_W-1:0] out_data,
  output logic                    out_valid
);
  localparam int FILL_W = $clog2(ORDER_MAX * HIST_D + 1);

  cfg_t cur, cfg_q;
  logic clr;
  logic rsvd_unused;
  logic signed [ACC_W-1:0] x_in, integ_y, comb_y;
  logic [SECT_W-1:0] dec_cnt, dsr_last;
  logic [FILL_W-1:0] fill, need;
  logic [SECT_W:0]   len_val;
  logic              emit;

  assign cur.rate  = cfg_rate[RATE_W-1:0];
  assign cur.order = cfg_shape[2*SECT_W+ORDER_W-1:2*SECT_W];
  assign cur.len   = cfg_shape[2*SECT_W-1:SECT_W];
  assign cur.dsr   = cfg_shape[SECT_W-1:0];
  assign rsvd_unused = ^{cfg_rate[7], cfg_shape[15:14]};

  assign clr  = (cur != cfg_q);
  assign x_in = in_bit ? ACC_W'(1) : '1;

  assign len_val  = (cfg_q.len == '0) ? (SECT_W+1)'(HIST_D) : {1'b0, cfg_q.len};
  assign need     = FILL_W'((int'(cfg_q.order) + ORDER_BASE) * int'(len_val));
  assign dsr_last = cfg_q.dsr - SECT_W'(1);
  assign emit     = mod_clk_en && (dec_cnt == dsr_last) &&
                    ((FILL_W+1)'(fill) + (FILL_W+1)'(1) >= (FILL_W+1)'(need));

  sinc_rate_div #(.W(RATE_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(clr), .code(cfg_q.rate), .tick(mod_clk_en)
  );

  sinc_integrators #(.DW(ACC_W), .NST(ORDER_MAX), .SEL_W(ORDER_W), .BASE(ORDER_BASE)) u_int (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(mod_clk_en),
    .x(x_in), .sel(cfg_q.order), .y(integ_y)
  );

  sinc_combs #(.DW(ACC_W), .NST(ORDER_MAX), .SEL_W(ORDER_W), .BASE(ORDER_BASE), .LW(SECT_W)) u_comb (
    .clk(clk), .rst_n(rst_n), .clr(clr), .en(mod_clk_en),
    .x(integ_y), .sel(cfg_q.order), .len(cfg_q.len), .y(comb_y)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q     <= '0;
      dec_cnt   <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
      out_data  <= '0;
    end else if (clr) begin
      cfg_q     <= cur;
      dec_cnt   <= '0;
      fill      <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= emit;
      if (emit) out_data <= comb_y;
      if (mod_clk_en) begin
        dec_cnt <= (dec_cnt == dsr_last) ? '0 : dec_cnt + SECT_W'(1);
        if (fill < need) fill <= fill + FILL_W'(1);
      end
    end
  end
endmodule

// File: rtl/sinc_decim_chk.sv
`timescale 1ns/1ps
module sinc_decim_chk #(
  parameter int DW = 38
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [7:0]           cfg_rate,
  input logic [15:0]          cfg_shape,
  input logic                 mod_clk_en,
  input logic signed [DW-1:0] out_data,
  input logic                 out_valid
);
  localparam logic signed [DW-1:0] LIM = DW'(1) << (DW - 2);

  logic [6:0]  rate_prev;
  logic [13:0] shape_prev;
  logic        cfg_moved;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rate_prev  <= '0;
      shape_prev <= '0;
    end else begin
      rate_prev  <= cfg_rate[6:0];
      shape_prev <= cfg_shape[13:0];
    end
  end
  assign cfg_moved = (cfg_rate[6:0] != rate_prev) || (cfg_shape[13:0] != shape_prev);

  a_r1_enable_spaced: assert property (@(posedge clk) disable iff (!rst_n)
    mod_clk_en |=> !mod_clk_en);
  a_r9_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |=> !out_valid);
  a_r9_follows_enable: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> $past(mod_clk_en));
  a_r10_data_held: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> $stable(out_data));
  a_r8_restart_wins: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_moved |=> !out_valid);
  a_r5_range: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_data <= LIM && out_data >= -LIM));
endmodule

bind sinc_decim sinc_decim_chk #(.DW(sinc_pkg::ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_shape(cfg_shape),
  .mod_clk_en(mod_clk_en), .out_data(out_data), .out_valid(out_valid)
);

// File: tb/sim_sinc_decim.sv
`timescale 1ns/1ps
module sim_sinc_decim;
  import sinc_pkg::*;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [7:0]  cfg_rate = '0;
  logic [15:0] cfg_shape = '0;
  logic in_bit = 1'b0;
  logic mod_clk_en;
  logic signed [ACC_W-1:0] out_data;
  logic out_valid;

  always #10 clk = ~clk;

  sinc_decim u0 (
    .clk(clk), .rst_n(rst_n), .cfg_rate(cfg_rate), .cfg_shape(cfg_shape),
    .in_bit(in_bit), .mod_clk_en(mod_clk_en), .out_data(out_data), .out_valid(out_valid)
  );

  int n_cmp = 0;
  int n_bad = 0;
  longint hist [0:ORDER_MAX][0:HIST_D-1];
  int m_ord, m_len, m_dsr;
  longint m_k;
  bit pend;
  longint pend_val;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(bit ok, string req, string what, longint act, longint exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic model_clear();
    foreach (hist[a, b]) hist[a][b] = 0;
    m_k = 0;
    pend = 0;
    m_ord = 3 + int'(cfg_shape[13:12]);
    m_len = (cfg_shape[11:6] == 0) ? 64 : int'(cfg_shape[11:6]);
    m_dsr = (cfg_shape[5:0] == 0) ? 64 : int'(cfg_shape[5:0]);
  endtask

  task automatic get_bit(int mode, longint idx, output bit b);
    case (mode)
      0: b = 1'b1;
      1: b = 1'b0;
      2: b = idx[0];
      3: begin
        b = lfsr[0];
        lfsr = {lfsr[0] ^ lfsr[2] ^ lfsr[3] ^ lfsr[5], lfsr[15:1]};
      end
      default: b = (idx % 5) != 0;
    endcase
  endtask

  // Cascade of moving sums over a zero-initialised history
  task automatic model_step(bit b);
    longint s;
    for (int j = HIST_D - 1; j > 0; j--) hist[0][j] = hist[0][j-1];
    hist[0][0] = b ? 1 : -1;
    for (int k = 1; k <= m_ord; k++) begin
      s = 0;
      for (int j = 0; j < m_len; j++) s += hist[k-1][j];
      for (int j = HIST_D - 1; j > 0; j--) hist[k][j] = hist[k][j-1];
      hist[k][0] = s;
    end
    m_k++;
    pend = ((m_k % m_dsr) == 0) && (m_k >= m_ord * m_len);
    pend_val = hist[m_ord][0];
  endtask

  task automatic observe(string req);
    if (pend)
      check(out_valid === 1'b1 && longint'(out_data) == pend_val, req,
            $sformatf("sample %0d (valid=%0b)", m_k, out_valid), longint'(out_data), pend_val);
    else if (out_valid)
      check(1'b0, req, "unexpected out_valid", 1, 0);
    pend = 0;
  endtask

  task automatic run(int n, int mode, string req);
    int got = 0;
    while (got < n) begin
      @(negedge clk);
      observe(req);
      if (mod_clk_en) begin
        bit b;
        get_bit(mode, m_k, b);
        in_bit = b;
        model_step(b);
        got++;
      end
    end
    @(negedge clk);
    observe(req);
  endtask

  task automatic set_cfg(logic [7:0] r, logic [15:0] s, string req);
    @(negedge clk);
    cfg_rate = r;
    cfg_shape = s;
    @(negedge clk);
    check(out_valid == 1'b0, req, "out_valid after config change", longint'(out_valid), 0);
    model_clear();
  endtask

  task automatic measure_period(int exp, string req);
    int gap = 0;
    int guard = 0;
    @(negedge clk);
    while (!mod_clk_en && guard < 400) begin @(negedge clk); guard++; end
    @(negedge clk); gap = 1;
    while (!mod_clk_en && gap < 400) begin @(negedge clk); gap++; end
    check(gap == exp, req, "enable period", gap, exp);
  endtask

  task automatic t_reset();
    check(out_valid == 1'b0, "R6", "out_valid at reset", longint'(out_valid), 0);
    check(out_data == '0, "R6", "out_data at reset", longint'(out_data), 0);
    measure_period(128, "R1");
  endtask

  task automatic t_rate();
    set_cfg(8'd5, 16'h0000, "R8");
    measure_period(5, "R1");
    set_cfg(8'd1, 16'h0000, "R8");
    measure_period(2, "R1");
  endtask

  task automatic t_order3_dc();
    set_cfg(8'd2, {2'b00, 2'b00, 6'd4, 6'd4}, "R8");
    run(40, 0, "R2");
  endtask

  task automatic t_len_alt();
    set_cfg(8'd3, {2'b00, 2'b01, 6'd3, 6'd5}, "R8");
    run(60, 2, "R3");
  endtask

  task automatic t_dec_one();
    set_cfg(8'd2, {2'b00, 2'b10, 6'd7, 6'd1}, "R8");
    run(80, 3, "R4");
  endtask

  task automatic t_extremes();
    set_cfg(8'd2, {2'b00, 2'b11, 6'd0, 6'd0}, "R8");
    run(576, 0, "R5");
    check(longint'(out_data) == (longint'(1) << 36), "R5", "positive extreme",
          longint'(out_data), longint'(1) << 36);
    set_cfg(8'd3, {2'b00, 2'b11, 6'd0, 6'd0}, "R8");
    run(450, 1, "R5");
    check(longint'(out_data) == -(longint'(1) << 36), "R5", "negative extreme",
          longint'(out_data), -(longint'(1) << 36));
  endtask

  task automatic t_reserved();
    set_cfg(8'd3, {2'b00, 2'b01, 6'd5, 6'd3}, "R8");
    run(30, 3, "R7");
    @(negedge clk);
    observe("R7");
    cfg_rate = cfg_rate | 8'h80;
    cfg_shape = cfg_shape | 16'hC000;
    run(30, 3, "R7");
  endtask

  task automatic t_hold();
    logic signed [ACC_W-1:0] held;
    int guard = 0;
    set_cfg(8'd2, {2'b00, 2'b00, 6'd1, 6'd3}, "R8");
    in_bit = 1'b1;
    @(negedge clk);
    while (!out_valid && guard < 50) begin @(negedge clk); guard++; end
    check(out_valid == 1'b1, "R9", "strobe seen", longint'(out_valid), 1);
    held = out_data;
    in_bit = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0, "R9", "strobe width", longint'(out_valid), 0);
    @(negedge clk);
    check(out_data == held, "R10", "data held between strobes", longint'(out_data), longint'(held));
  endtask

  task automatic t_clash();
    bit hit = 0;
    set_cfg(8'd2, {2'b00, 2'b00, 6'd2, 6'd2}, "R8");
    while (!hit) begin
      @(negedge clk);
      observe("R8");
      if (mod_clk_en) begin
        if (m_k >= 8 && ((m_k + 1) % m_dsr) == 0) begin
          cfg_shape = {2'b00, 2'b00, 6'd3, 6'd2};
          hit = 1;
        end else begin
          in_bit = 1'b1;
          model_step(1'b1);
        end
      end
    end
    @(negedge clk);
    check(out_valid == 1'b0, "R8", "due output dropped on restart", longint'(out_valid), 0);
    model_clear();
    run(24, 4, "R8");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_rate();
    t_order3_dc();
    t_len_alt();
    t_dec_one();
    t_extremes();
    t_reserved();
    t_hold();
    t_clash();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #4ms;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule